// File: doc/BRIEF.md
# Two-Slot Hot-Plug Power Sequencing Controller

This block is the digital core of a two-slot add-in card power switch. For each slot it decides whether the main switch (one enable for both the 12 V and 3.3 V paths) and the auxiliary switch may conduct. It also drives an active-low fault output and an active-low power-good output. It sees the analog side only through logic-level flags: a regulation-active flag per supply path, input-supply-good flags, output-compliant flags and one over-temperature flag. Gate modulation, current sensing and open-drain drive sit outside.

Every pin input passes through a two-flop synchronizer, so outputs react two clock edges after an input changes. Each slot has a main and an aux breaker timer. The timer counts while its regulation flag stays up and restarts whenever the flag drops. When it reaches the configured duration, it sets that path's fault latch. A chip-wide mode input picks latch-off, where a latch waits for its own enable to go low, or periodic retry, where a sequencer clears the latches after a fixed interval. An active-low force-on input bypasses the enables and the breakers, but not the standby-supply check.

Top module: `hp_slot_ctrl`

## Requirements
- R1: While `rst` is high and after its release, every slot holds `main_gate`=0, `aux_gate`=0, `fault_n`=1 and `pgood_n`=1, whatever the inputs.
- R2: While `card_absent` of a slot is 1, that slot's `main_en`, `aux_en` and `force_n` have no effect: both gates stay 0.
- R3: When `card_absent` of a slot rises while its switches conduct, both of its gates fall on the same edge, the second rising clock edge after the pin change. The other slot is unaffected.
- R4: `main_gate` is 1 only with the card present, `stby_ok`=1, `main_en`=1, `in12_ok`=1, `in3_ok`=1 and no main fault. `aux_gate` is 1 only with the card present, `stby_ok`=1, `aux_en`=1 and no aux fault.
- R5: With the card present and `stby_ok`=1, `force_n`=0 turns on both gates regardless of the enables, the input-good flags and the regulation flags. While forced, no fault latch is set. `stby_ok`=0 still keeps both gates off.
- R6: While force-on is in effect, `fault_n` and `pgood_n` are both 1, even with `over_temp`=1.
- R7: When `oc_main` is held for REG_CYC synchronized cycles while the main gate conducts, the main fault latch sets. `main_gate` then falls on edge REG_CYC+2 after the pin rose, `fault_n` goes 0, and `aux_gate` stays on. If the flag drops earlier, the timer starts again from zero.
- R8: When `oc_aux` is held for REG_CYC synchronized cycles while the aux gate conducts, the aux fault latch sets. `aux_gate` falls, `main_gate` stays on, and `fault_n` goes 0.
- R9: In latch-off mode (`latch_mode`=1) a main fault stays latched, however long it waits, until `main_en` goes low. Cycling `aux_en` does not clear it.
- R10: With both latches set, cycling `main_en` restores `main_gate` but `fault_n` stays 0. Only cycling `aux_en` as well releases `fault_n`.
- R11: `over_temp`=1 drives `fault_n` low on every slot that is not forced, without affecting the gates.
- R12: In retry mode (`latch_mode`=0) the slot's fault latches clear by themselves RETRY_CYC cycles after the trip, and the gates turn back on with the enables still high.
- R13: `pgood_n` is 0 only when not forced, with both gates on and `v12_ok`, `v3_ok` and `vaux_ok` all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| card_absent | input | NSLOT | Per slot, 1 = no card present |
| main_en | input | NSLOT | Per slot main supply enable, active high |
| aux_en | input | NSLOT | Per slot aux supply enable, active high |
| force_n | input | NSLOT | Per slot force-on, active low |
| oc_main | input | NSLOT | Main current-regulation active flag |
| oc_aux | input | NSLOT | Aux current-regulation active flag |
| in12_ok | input | NSLOT | 12 V input above lockout |
| in3_ok | input | NSLOT | 3.3 V input above lockout |
| stby_ok | input | NSLOT | Standby bias above lockout |
| v12_ok | input | NSLOT | 12 V output compliant |
| v3_ok | input | NSLOT | 3.3 V output compliant |
| vaux_ok | input | NSLOT | Aux output compliant |
| latch_mode | input | 1 | 1 = latch-off, 0 = periodic retry |
| over_temp | input | 1 | Die over-temperature flag |
| main_gate | output | NSLOT | Main switch enable |
| aux_gate | output | NSLOT | Aux switch enable |
| fault_n | output | NSLOT | Fault indication, active low |
| pgood_n | output | NSLOT | Power good, active low |

## Verification
A breaker timer that fails to restart shows up as `main_gate` dropping after a train of short regulation bursts. A timer that counts wrong moves the falling edge of the gate away from edge REG_CYC+2. A latch that clears on the wrong enable, or not at all, shows as a gate that comes back or stays dark within three cycles of the enable cycle. In retry mode the fault shows on `fault_n` for one retry interval. A synchronizer stage missing or added shifts every output transition by one edge, which the card-removal latency check catches directly.

// File: rtl/hp_pkg.sv
package hp_pkg;

    typedef struct packed {
        logic absent;
        logic main_en;
        logic aux_en;
        logic force_n;
        logic oc_main;
        logic oc_aux;
        logic in12_ok;
        logic in3_ok;
        logic stby_ok;
        logic v12_ok;
        logic v3_ok;
        logic vaux_ok;
    } slot_in_t;

    localparam int SLOT_IN_W = $bits(slot_in_t);

    // idle values: no card, force released, everything else low
    localparam slot_in_t SLOT_IN_IDLE = '{absent: 1'b1, force_n: 1'b1, default: 1'b0};

    typedef struct packed {
        logic main_gate;
        logic aux_gate;
        logic fault_n;
        logic pgood_n;
    } slot_out_t;

    typedef struct packed {
        logic main_flt;
        logic aux_flt;
    } slot_flt_t;

    typedef struct packed {
        logic latch_mode;
        logic over_temp;
    } glob_in_t;

    localparam int GLOB_IN_W = $bits(glob_in_t);
    localparam glob_in_t GLOB_IN_IDLE = '{latch_mode: 1'b1, over_temp: 1'b0};

    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/hp_trip_timer.sv
module hp_trip_timer
    import hp_pkg::*;
#(
    parameter int CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,   // path conducting under normal control
    input  logic oc,    // regulation active
    input  logic clr,   // latch clear request
    output logic flt
);
    localparam int CW = cnt_w(CYC);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    logic [CW-1:0] cnt;
    logic          run;
    logic          hit;

    assign run = arm & oc;
    assign hit = run & (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!run || hit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flt <= 1'b0;
        end else if (clr) begin
            flt <= 1'b0;
        end else if (hit) begin
            flt <= 1'b1;
        end
    end
endmodule

// File: rtl/hp_retry_seq.sv
module hp_retry_seq
    import hp_pkg::*;
#(
    parameter int CYC = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic fire
);
    localparam int CW = cnt_w(CYC);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    logic [CW-1:0] cnt;

    assign fire = active & (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!active || fire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hp_slot.sv
module hp_slot
    import hp_pkg::*;
#(
    parameter int REG_CYC   = 1000,
    parameter int RETRY_CYC = 100000
) (
    input  logic      clk,
    input  logic      rst,
    input  slot_in_t  si,
    input  logic      latch_mode,
    input  logic      over_temp,
    output slot_out_t so,
    output slot_flt_t flt
);
    logic card;
    logic forced;
    logic main_on;
    logic aux_on;
    logic retry_fire;
    logic main_clr;
    logic aux_clr;
    logic out_good;

    assign card   = ~si.absent;
    assign forced = card & ~si.force_n;

    assign main_on = card & si.stby_ok &
                     (forced | (si.main_en & si.in12_ok & si.in3_ok & ~flt.main_flt));
    assign aux_on  = card & si.stby_ok &
                     (forced | (si.aux_en & ~flt.aux_flt));

    assign main_clr = (card & ~si.main_en) | retry_fire;
    assign aux_clr  = (card & ~si.aux_en)  | retry_fire;

    hp_trip_timer #(.CYC(REG_CYC)) u_main_tmr (
        .clk (clk),
        .rst (rst),
        .arm (main_on & ~forced),
        .oc  (si.oc_main),
        .clr (main_clr),
        .flt (flt.main_flt)
    );

    hp_trip_timer #(.CYC(REG_CYC)) u_aux_tmr (
        .clk (clk),
        .rst (rst),
        .arm (aux_on & ~forced),
        .oc  (si.oc_aux),
        .clr (aux_clr),
        .flt (flt.aux_flt)
    );

    hp_retry_seq #(.CYC(RETRY_CYC)) u_retry (
        .clk    (clk),
        .rst    (rst),
        .active ((flt.main_flt | flt.aux_flt) & ~latch_mode),
        .fire   (retry_fire)
    );

    assign out_good = si.v12_ok & si.v3_ok & si.vaux_ok;

    always_comb begin
        so.main_gate = main_on;
        so.aux_gate  = aux_on;
        so.fault_n   = forced | ~(flt.main_flt | flt.aux_flt | over_temp);
        so.pgood_n   = ~(~forced & main_on & aux_on & out_good);
    end
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
    import hp_pkg::*;
#(
    parameter int NSLOT     = 2,
    parameter int REG_CYC   = 1000,
    parameter int RETRY_CYC = 100000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSLOT-1:0] card_absent,
    input  logic [NSLOT-1:0] main_en,
    input  logic [NSLOT-1:0] aux_en,
    input  logic [NSLOT-1:0] force_n,
    input  logic [NSLOT-1:0] oc_main,
    input  logic [NSLOT-1:0] oc_aux,
    input  logic [NSLOT-1:0] in12_ok,
    input  logic [NSLOT-1:0] in3_ok,
    input  logic [NSLOT-1:0] stby_ok,
    input  logic [NSLOT-1:0] v12_ok,
    input  logic [NSLOT-1:0] v3_ok,
    input  logic [NSLOT-1:0] vaux_ok,
    input  logic             latch_mode,
    input  logic             over_temp,
    output logic [NSLOT-1:0] main_gate,
    output logic [NSLOT-1:0] aux_gate,
    output logic [NSLOT-1:0] fault_n,
    output logic [NSLOT-1:0] pgood_n
);
    glob_in_t glob_raw;
    glob_in_t glob_s;

    // synchronized views, also observed by the bound checker
    logic [NSLOT-1:0] s_absent;
    logic [NSLOT-1:0] s_main_en;
    logic [NSLOT-1:0] s_aux_en;
    logic [NSLOT-1:0] s_oc_main;
    logic [NSLOT-1:0] s_oc_aux;
    logic [NSLOT-1:0] main_flt;
    logic [NSLOT-1:0] aux_flt;
    logic             s_latch_mode;

    assign glob_raw.latch_mode = latch_mode;
    assign glob_raw.over_temp  = over_temp;

    hp_sync #(
        .W       (GLOB_IN_W),
        .RST_VAL (GLOB_IN_W'(GLOB_IN_IDLE))
    ) u_sync_glob (
        .clk (clk),
        .rst (rst),
        .d   (glob_raw),
        .q   (glob_s)
    );

    assign s_latch_mode = glob_s.latch_mode;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        slot_in_t  raw;
        slot_in_t  syn;
        slot_out_t so;
        slot_flt_t fl;

        always_comb begin
            raw.absent  = card_absent[i];
            raw.main_en = main_en[i];
            raw.aux_en  = aux_en[i];
            raw.force_n = force_n[i];
            raw.oc_main = oc_main[i];
            raw.oc_aux  = oc_aux[i];
            raw.in12_ok = in12_ok[i];
            raw.in3_ok  = in3_ok[i];
            raw.stby_ok = stby_ok[i];
            raw.v12_ok  = v12_ok[i];
            raw.v3_ok   = v3_ok[i];
            raw.vaux_ok = vaux_ok[i];
        end

        hp_sync #(
            .W       (SLOT_IN_W),
            .RST_VAL (SLOT_IN_W'(SLOT_IN_IDLE))
        ) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw),
            .q   (syn)
        );

        hp_slot #(
            .REG_CYC   (REG_CYC),
            .RETRY_CYC (RETRY_CYC)
        ) u_slot (
            .clk        (clk),
            .rst        (rst),
            .si         (syn),
            .latch_mode (glob_s.latch_mode),
            .over_temp  (glob_s.over_temp),
            .so         (so),
            .flt        (fl)
        );

        assign main_gate[i] = so.main_gate;
        assign aux_gate[i]  = so.aux_gate;
        assign fault_n[i]   = so.fault_n;
        assign pgood_n[i]   = so.pgood_n;

        assign s_absent[i]  = syn.absent;
        assign s_main_en[i] = syn.main_en;
        assign s_aux_en[i]  = syn.aux_en;
        assign s_oc_main[i] = syn.oc_main;
        assign s_oc_aux[i]  = syn.oc_aux;
        assign main_flt[i]  = fl.main_flt;
        assign aux_flt[i]   = fl.aux_flt;
    end
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
module hp_slot_ctrl_chk #(
    parameter int NSLOT = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [NSLOT-1:0] card_absent,
    input logic [NSLOT-1:0] force_n,
    input logic [NSLOT-1:0] stby_ok,
    input logic [NSLOT-1:0] v12_ok,
    input logic [NSLOT-1:0] v3_ok,
    input logic [NSLOT-1:0] vaux_ok,
    input logic             over_temp,
    input logic [NSLOT-1:0] main_gate,
    input logic [NSLOT-1:0] aux_gate,
    input logic [NSLOT-1:0] fault_n,
    input logic [NSLOT-1:0] pgood_n,
    input logic [NSLOT-1:0] s_main_en,
    input logic [NSLOT-1:0] s_aux_en,
    input logic [NSLOT-1:0] s_oc_main,
    input logic [NSLOT-1:0] s_oc_aux,
    input logic [NSLOT-1:0] main_flt,
    input logic [NSLOT-1:0] aux_flt,
    input logic             s_latch_mode
);
    logic [1:0] age;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end
    assign warm = (age == 2'd3);

    for (genvar i = 0; i < NSLOT; i++) begin : g_chk
        a_r2_absent_gates_off: assert property (@(posedge clk) disable iff (rst)
            warm && card_absent[i] && $past(card_absent[i]) && $past(card_absent[i], 2)
            |-> !main_gate[i] && !aux_gate[i]);

        a_r4_gate_needs_stby: assert property (@(posedge clk) disable iff (rst)
            warm && (main_gate[i] || aux_gate[i]) |-> $past(stby_ok[i], 2));

        a_r6_force_releases: assert property (@(posedge clk) disable iff (rst)
            warm && !$past(force_n[i], 2) && !$past(card_absent[i], 2) && $past(stby_ok[i], 2)
            |-> fault_n[i] && pgood_n[i]);

        a_r7_main_trip_cause: assert property (@(posedge clk) disable iff (rst)
            $rose(main_flt[i]) |-> $past(s_oc_main[i]));

        a_r8_aux_trip_cause: assert property (@(posedge clk) disable iff (rst)
            $rose(aux_flt[i]) |-> $past(s_oc_aux[i]));

        a_r9_main_clear_cause: assert property (@(posedge clk) disable iff (rst)
            $fell(main_flt[i]) |-> $past(!s_main_en[i] || !s_latch_mode));

        a_r10_aux_clear_cause: assert property (@(posedge clk) disable iff (rst)
            $fell(aux_flt[i]) |-> $past(!s_aux_en[i] || !s_latch_mode));

        a_r11_otemp_fault: assert property (@(posedge clk) disable iff (rst)
            warm && $past(over_temp, 2) && $past(force_n[i], 2) |-> !fault_n[i]);

        a_r13_pgood_needs_ok: assert property (@(posedge clk) disable iff (rst)
            warm && !pgood_n[i] |-> $past(v12_ok[i] && v3_ok[i] && vaux_ok[i], 2));
    end
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk #(.NSLOT(NSLOT)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .card_absent  (card_absent),
    .force_n      (force_n),
    .stby_ok      (stby_ok),
    .v12_ok       (v12_ok),
    .v3_ok        (v3_ok),
    .vaux_ok      (vaux_ok),
    .over_temp    (over_temp),
    .main_gate    (main_gate),
    .aux_gate     (aux_gate),
    .fault_n      (fault_n),
    .pgood_n      (pgood_n),
    .s_main_en    (s_main_en),
    .s_aux_en     (s_aux_en),
    .s_oc_main    (s_oc_main),
    .s_oc_aux     (s_oc_aux),
    .main_flt     (main_flt),
    .aux_flt      (aux_flt),
    .s_latch_mode (s_latch_mode)
);

// File: tb/tb_hp_slot_ctrl.sv
module tb_hp_slot_ctrl;
    localparam int NSLOT = 2;
    localparam int REG   = 8;
    localparam int RETRY = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NSLOT-1:0] card_absent, main_en, aux_en, force_n, oc_main, oc_aux;
    logic [NSLOT-1:0] in12_ok, in3_ok, stby_ok, v12_ok, v3_ok, vaux_ok;
    logic             latch_mode, over_temp;
    logic [NSLOT-1:0] main_gate, aux_gate, fault_n, pgood_n;

    always #2 clk = ~clk;

    hp_slot_ctrl #(.NSLOT(NSLOT), .REG_CYC(REG), .RETRY_CYC(RETRY)) dut (
        .clk(clk), .rst(rst), .card_absent(card_absent), .main_en(main_en),
        .aux_en(aux_en), .force_n(force_n), .oc_main(oc_main), .oc_aux(oc_aux),
        .in12_ok(in12_ok), .in3_ok(in3_ok), .stby_ok(stby_ok), .v12_ok(v12_ok),
        .v3_ok(v3_ok), .vaux_ok(vaux_ok), .latch_mode(latch_mode),
        .over_temp(over_temp), .main_gate(main_gate), .aux_gate(aux_gate),
        .fault_n(fault_n), .pgood_n(pgood_n)
    );

    typedef struct packed {
        logic [3:0] rq;
        logic absent, men, aen, fn, stby, i12, i3, vok, ot;
        logic mg, ag, fl, pg;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        //  rq     abs men aen fn  stb i12 i3  vok ot    mg  ag  fl  pg
        '{4'd2,  1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b1,1'b1}, // R2
        '{4'd13, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0, 1'b1,1'b1,1'b1,1'b0}, // R13
        '{4'd13, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b1}, // R13
        '{4'd4,  1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b1,1'b1,1'b1}, // R4
        '{4'd4,  1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0, 1'b0,1'b1,1'b1,1'b1}, // R4
        '{4'd4,  1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b1,1'b1,1'b1}, // R4
        '{4'd4,  1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b1,1'b1}, // R4
        '{4'd5,  1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1,1'b1}, // R5
        '{4'd5,  1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b1,1'b1}, // R5
        '{4'd11, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b0,1'b0}, // R11
        '{4'd6,  1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1}, // R6
        '{4'd4,  1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b1,1'b1}  // R4
    };

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic slot_on(input int s);
        card_absent[s] = 1'b0; main_en[s] = 1'b1; aux_en[s] = 1'b1; force_n[s] = 1'b1;
        oc_main[s] = 1'b0; oc_aux[s] = 1'b0; in12_ok[s] = 1'b1; in3_ok[s] = 1'b1;
        stby_ok[s] = 1'b1; v12_ok[s] = 1'b1; v3_ok[s] = 1'b1; vaux_ok[s] = 1'b1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        card_absent = '1; main_en = '0; aux_en = '0; force_n = '1; oc_main = '0; oc_aux = '0;
        in12_ok = '0; in3_ok = '0; stby_ok = '0; v12_ok = '0; v3_ok = '0; vaux_ok = '0;
        latch_mode = 1'b1; over_temp = 1'b0;
        @(negedge clk);
        slot_on(0);
        tick(4);
        // R1: outputs held idle in reset even with slot 0 asking for power
        chk("R1", "main_gate0 in reset", main_gate[0], 1'b0);
        chk("R1", "aux_gate0 in reset", aux_gate[0], 1'b0);
        chk("R1", "fault_n0 in reset", fault_n[0], 1'b1);
        chk("R1", "pgood_n1 in reset", pgood_n[1], 1'b1);
        rst = 1'b0;
        chk("R1", "main_gate1 after release", main_gate[1], 1'b0);

        for (int k = 0; k < NV; k++) begin
            card_absent[0] = VEC[k].absent; main_en[0] = VEC[k].men; aux_en[0] = VEC[k].aen;
            force_n[0] = VEC[k].fn; stby_ok[0] = VEC[k].stby; in12_ok[0] = VEC[k].i12;
            in3_ok[0] = VEC[k].i3; v12_ok[0] = VEC[k].vok; v3_ok[0] = VEC[k].vok;
            vaux_ok[0] = VEC[k].vok; over_temp = VEC[k].ot;
            tick(3);
            chk($sformatf("R%0d", VEC[k].rq), $sformatf("vec %0d main_gate", k), main_gate[0], VEC[k].mg);
            chk($sformatf("R%0d", VEC[k].rq), $sformatf("vec %0d aux_gate", k), aux_gate[0], VEC[k].ag);
            chk($sformatf("R%0d", VEC[k].rq), $sformatf("vec %0d fault_n", k), fault_n[0], VEC[k].fl);
            chk($sformatf("R%0d", VEC[k].rq), $sformatf("vec %0d pgood_n", k), pgood_n[0], VEC[k].pg);
            chk("R2", $sformatf("vec %0d slot1 idle", k), main_gate[1], 1'b0);
        end
        over_temp = 1'b0;
        slot_on(0);
        slot_on(1);
        tick(3);
        chk("R4", "both slots on", main_gate[0] & main_gate[1] & aux_gate[1], 1'b1);

        // R3: removal latency is exactly two edges
        card_absent[0] = 1'b1;
        tick(1);
        chk("R3", "main_gate0 after one edge", main_gate[0], 1'b1);
        tick(1);
        chk("R3", "main_gate0 after two edges", main_gate[0], 1'b0);
        chk("R3", "aux_gate0 after two edges", aux_gate[0], 1'b0);
        chk("R3", "slot1 unaffected", main_gate[1], 1'b1);
        slot_on(0);
        tick(3);

        // R7: short bursts do not accumulate
        for (int b = 0; b < 2; b++) begin
            oc_main[0] = 1'b1; tick(4);
            oc_main[0] = 1'b0; tick(4);
        end
        chk("R7", "main_gate0 after short bursts", main_gate[0], 1'b1);
        chk("R7", "fault_n0 after short bursts", fault_n[0], 1'b1);
        oc_main[0] = 1'b1;
        tick(REG + 1);
        chk("R7", "main_gate0 one edge before trip", main_gate[0], 1'b1);
        tick(1);
        chk("R7", "main_gate0 at trip edge", main_gate[0], 1'b0);
        chk("R7", "aux_gate0 kept on", aux_gate[0], 1'b1);
        chk("R7", "fault_n0 low", fault_n[0], 1'b0);
        chk("R7", "slot1 main unaffected", main_gate[1], 1'b1);
        oc_main[0] = 1'b0;

        // R12: latch-off mode never retries
        tick(RETRY + 8);
        chk("R12", "latched main stays off", main_gate[0], 1'b0);

        // R9: aux cycling leaves main latch, main cycling clears it
        aux_en[0] = 1'b0; tick(4);
        aux_en[0] = 1'b1; tick(4);
        chk("R9", "main_gate0 after aux cycle", main_gate[0], 1'b0);
        chk("R9", "fault_n0 after aux cycle", fault_n[0], 1'b0);
        main_en[0] = 1'b0; tick(3);
        main_en[0] = 1'b1; tick(3);
        chk("R9", "main_gate0 after main cycle", main_gate[0], 1'b1);
        chk("R9", "fault_n0 after main cycle", fault_n[0], 1'b1);

        // R8: aux breaker
        oc_aux[0] = 1'b1;
        tick(REG + 4);
        chk("R8", "aux_gate0 tripped", aux_gate[0], 1'b0);
        chk("R8", "main_gate0 kept on", main_gate[0], 1'b1);
        chk("R8", "fault_n0 low", fault_n[0], 1'b0);
        oc_aux[0] = 1'b0;

        // R10: both latched, both enables must cycle
        oc_main[0] = 1'b1;
        tick(REG + 4);
        oc_main[0] = 1'b0;
        tick(2);
        chk("R10", "main_gate0 tripped", main_gate[0], 1'b0);
        main_en[0] = 1'b0; tick(3);
        main_en[0] = 1'b1; tick(3);
        chk("R10", "main_gate0 restored", main_gate[0], 1'b1);
        chk("R10", "fault_n0 held by aux latch", fault_n[0], 1'b0);
        chk("R10", "aux_gate0 still off", aux_gate[0], 1'b0);
        aux_en[0] = 1'b0; tick(3);
        aux_en[0] = 1'b1; tick(3);
        chk("R10", "aux_gate0 restored", aux_gate[0], 1'b1);
        chk("R10", "fault_n0 released", fault_n[0], 1'b1);

        // R5: force overrides regulation breakers
        force_n[0] = 1'b0; oc_main[0] = 1'b1; oc_aux[0] = 1'b1;
        tick(REG * 3);
        chk("R5", "forced main stays on", main_gate[0], 1'b1);
        chk("R5", "forced aux stays on", aux_gate[0], 1'b1);
        chk("R6", "forced fault_n released", fault_n[0], 1'b1);
        oc_main[0] = 1'b0; oc_aux[0] = 1'b0; tick(3);
        force_n[0] = 1'b1; tick(3);
        chk("R5", "no latch after force", main_gate[0] & aux_gate[0] & fault_n[0], 1'b1);

        // R12: retry mode clears by itself
        latch_mode = 1'b0; tick(3);
        oc_main[0] = 1'b1;
        tick(REG + 4);
        oc_main[0] = 1'b0;
        chk("R12", "retry main off after trip", main_gate[0], 1'b0);
        chk("R12", "retry fault_n low", fault_n[0], 1'b0);
        tick(10);
        chk("R12", "retry main still off mid interval", main_gate[0], 1'b0);
        tick(20);
        chk("R12", "retry main back on", main_gate[0], 1'b1);
        chk("R12", "retry fault_n released", fault_n[0], 1'b1);
        latch_mode = 1'b1;

        // R11: over-temperature on both slots, gates untouched
        over_temp = 1'b1; tick(3);
        chk("R11", "fault_n0 on otemp", fault_n[0], 1'b0);
        chk("R11", "fault_n1 on otemp", fault_n[1], 1'b0);
        chk("R11", "main_gate0 on otemp", main_gate[0], 1'b1);
        over_temp = 1'b0; tick(3);

        // R13: a single non-compliant output drops power good
        vaux_ok[0] = 1'b0; tick(3);
        chk("R13", "pgood_n0 with aux out low", pgood_n[0], 1'b1);
        vaux_ok[0] = 1'b1; tick(3);
        chk("R13", "pgood_n0 all compliant", pgood_n[0], 1'b0);

        done = 1'b1;
        finish_run();
    end
endmodule